// File: doc/BRIEF.md
# Descriptor-Table Bus-Master DMA Engine

This block moves disk sector data between a device-side word stream and system memory without processor help. Software places a table of 8-byte descriptors in memory, each naming a buffer address and a byte count, with a flag on the final entry. Software then writes the table's base address and sets the start bit. The engine fetches each descriptor and moves 16-bit words in either direction until the table is used up. It stops early if the device reports that it has finished.

A small byte-addressed register port holds a command byte, a status byte and the 32-bit table pointer. The status byte carries an active bit, a sticky error bit and a sticky interrupt bit. The interrupt bit drives the interrupt output. Read together, active and interrupt tell software how the transfer ended. Interrupt set with active clear means the table and the device ended together. Interrupt set with active still set means the device finished first. Active clear with no interrupt means the table ran out while the device still had data.

Top module: `prd_dma_engine`

## Requirements
- R1: Registers sit at byte offsets 0x0 (command byte), 0x2 (status byte) and 0x4 (32-bit table pointer). Each reads back over `reg_rdata`. After reset, all three read zero, `irq` is low and no memory request is made.
- R2: A write to the command register that changes bit 0 from 0 to 1 sets status bit 0 (active) and starts fetching descriptors at the table pointer.
- R3: When command bit 3 is 1 at start, words taken from the device are written to memory. When it is 0, words read from memory are handed to the device.
- R4: A descriptor is four consecutive halfwords: buffer address low, buffer address high, byte count, and a final halfword whose bit 15 marks the last entry. Count bit 0 is ignored. Entries follow each other at 8-byte steps, and buffers are walked upward in 2-byte steps.
- R5: A byte count field of zero stands for 65536 bytes.
- R6: When the descriptor total matches the device transfer, active clears as the last word moves. The device interrupt then makes the status read exactly 0x04.
- R7: A rising edge on `dev_irq` while a transfer is active sets status bit 2 and halts all data movement, while active stays set (status 0x05).
- R8: When the last descriptor is used up, active clears and the interrupt bit is left unchanged. A device that still has data then sees no further ready.
- R9: An error response on the memory port sets status bit 1 (error), clears active and aborts the transfer. Writing 1 to status bit 1 clears it.
- R10: Status bit 2 is sticky and clears when 1 is written to it. The `irq` output equals status bit 2 at all times.
- R11: Writing the command register with bit 0 clear stops any transfer in progress and clears active. No memory or device handshakes follow.
- R12: Writes to the table pointer are ignored while active is set and take effect while it is clear.
- R13: The direction is captured when the start bit rises. Later writes to command bit 3 do not change a running transfer.
- R14: A memory request holds its address until it is acknowledged. Each access is served exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address (halfword aligned) |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory acknowledge |
| mem_err | input | 1 | Error response, qualified by `mem_ack` |
| dev_in_valid | input | 1 | Device offers a word for memory |
| dev_in_data | input | 16 | Word from the device |
| dev_in_ready | output | 1 | Engine accepts the device word |
| dev_out_valid | output | 1 | Engine offers a word to the device |
| dev_out_data | output | 16 | Word for the device |
| dev_out_ready | input | 1 | Device accepts the word |
| dev_irq | input | 1 | Device end-of-command interrupt |
| irq | output | 1 | Interrupt output, equal to status bit 2 |

## Verification
The hardest case to reach is the device finishing while descriptors still hold bytes, in particular against a zero-count entry that stands for 64 KiB. Running that transfer to its end would take far too long. The bench instead gives the device a short run of ten words against a zero-count descriptor. It watches the memory write count until all ten words have landed, then raises the device interrupt while the engine waits for more. It then checks that active stayed set, that no further memory writes happen, and that a table pointer write in this held state is refused.

// File: rtl/dma_pkg.sv
package dma_pkg;

  localparam int PTR_W      = 32;
  localparam int HW_W       = 16;
  localparam int CNT_W      = 17;
  localparam int DESC_BYTES = 8;
  localparam int HW_BYTES   = 2;

  localparam int OFS_CMD = 0;
  localparam int OFS_STS = 2;
  localparam int OFS_PTR = 4;

  localparam int CMD_GO    = 0;
  localparam int CMD_TOMEM = 3;

  localparam int ST_ACT = 0;
  localparam int ST_ERR = 1;
  localparam int ST_INT = 2;

  localparam int LAST_FLAG = 15;

  typedef enum logic [2:0] {
    W_IDLE,
    W_FETCH,
    W_MRD,
    W_DOUT,
    W_DIN,
    W_MWR,
    W_HOLD
  } walk_t;

endpackage

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_pkg::*;
#(
  parameter int REG_AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              dev_irq,
  input  logic              end_i,
  input  logic              fault_i,
  output logic              go_o,
  output logic              go_dir_o,
  output logic              abort_o,
  output logic              halt_o,
  output logic [PTR_W-1:0]  base_o,
  output logic              irq_o
);

  logic [7:0]       cmd_q, cmd_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             act_q, act_d;
  logic             err_q, err_d;
  logic             int_q, int_d;
  logic             irqs_q;

  logic wr_cmd, wr_sts, wr_ptr, dev_rise;

  assign wr_cmd   = reg_wr && (reg_addr == REG_AW'(OFS_CMD));
  assign wr_sts   = reg_wr && (reg_addr == REG_AW'(OFS_STS));
  assign wr_ptr   = reg_wr && (reg_addr == REG_AW'(OFS_PTR));
  assign dev_rise = dev_irq && !irqs_q;

  always_comb begin
    cmd_d    = cmd_q;
    ptr_d    = ptr_q;
    act_d    = act_q;
    err_d    = err_q;
    int_d    = int_q;
    go_o     = 1'b0;
    go_dir_o = reg_wdata[CMD_TOMEM];
    abort_o  = 1'b0;

    if (wr_cmd) begin
      cmd_d = reg_wdata[7:0];
      if (reg_wdata[CMD_GO] && !cmd_q[CMD_GO]) go_o = 1'b1;
      if (!reg_wdata[CMD_GO])                  abort_o = 1'b1;
    end

    if (wr_ptr && !act_q) ptr_d = reg_wdata[PTR_W-1:0];

    if (go_o)                                   act_d = 1'b1;
    else if (abort_o || end_i || fault_i)       act_d = 1'b0;

    if (fault_i)                                err_d = 1'b0 | 1'b1;
    else if (wr_sts && reg_wdata[ST_ERR])       err_d = 1'b0;

    if (dev_rise)                               int_d = 1'b1;
    else if (wr_sts && reg_wdata[ST_INT])       int_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      ptr_q  <= '0;
      act_q  <= 1'b0;
      err_q  <= 1'b0;
      int_q  <= 1'b0;
      irqs_q <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      ptr_q  <= ptr_d;
      act_q  <= act_d;
      err_q  <= err_d;
      int_q  <= int_d;
      irqs_q <= dev_irq;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == REG_AW'(OFS_CMD))      reg_rdata[7:0] = cmd_q;
    else if (reg_addr == REG_AW'(OFS_STS)) begin
      reg_rdata[ST_ACT] = act_q;
      reg_rdata[ST_ERR] = err_q;
      reg_rdata[ST_INT] = int_q;
    end
    else if (reg_addr == REG_AW'(OFS_PTR)) reg_rdata[PTR_W-1:0] = ptr_q;
  end

  assign halt_o = dev_rise;
  assign base_o = ptr_q;
  assign irq_o  = int_q;

  // R9: a memory fault leaves error set and active clear
  a_r9_fault_clears: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> (err_q && !act_q));

  // R7 / R10: device interrupt edge always lands in the sticky bit
  a_r10_int_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rise |=> irq_o);

  // R12: pointer is frozen while active
  a_r12_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && wr_ptr) |=> $stable(ptr_q));

  // R8: running out of descriptors never raises the interrupt by itself
  a_r8_end_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (end_i && !dev_rise && !int_q) |=> (!act_q && !int_q));

endmodule

// File: rtl/dma_walker.sv
module dma_walker
  import dma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic             go_dir_i,
  input  logic             abort_i,
  input  logic             halt_i,
  input  logic [PTR_W-1:0] base_i,
  output logic             end_o,
  output logic             fault_o,
  output logic             mem_req,
  output logic             mem_we,
  output logic [PTR_W-1:0] mem_addr,
  output logic [HW_W-1:0]  mem_wdata,
  input  logic [HW_W-1:0]  mem_rdata,
  input  logic             mem_ack,
  input  logic             mem_err,
  input  logic             dev_in_valid,
  input  logic [HW_W-1:0]  dev_in_data,
  output logic             dev_in_ready,
  output logic             dev_out_valid,
  output logic [HW_W-1:0]  dev_out_data,
  input  logic             dev_out_ready
);

  walk_t            st_q, st_d;
  logic [PTR_W-1:0] tptr_q, tptr_d;
  logic [1:0]       fidx_q, fidx_d;
  logic [PTR_W-1:0] badr_q, badr_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             eot_q, eot_d;
  logic [HW_W-1:0]  dbuf_q, dbuf_d;
  logic             dir_q, dir_d;
  logic             step;
  walk_t            move_st;

  assign move_st = dir_q ? W_DIN : W_MRD;

  always_comb begin
    st_d    = st_q;
    tptr_d  = tptr_q;
    fidx_d  = fidx_q;
    badr_d  = badr_q;
    rem_d   = rem_q;
    eot_d   = eot_q;
    dbuf_d  = dbuf_q;
    dir_d   = dir_q;
    end_o   = 1'b0;
    fault_o = 1'b0;
    step    = 1'b0;

    if (abort_i) begin
      st_d = W_IDLE;
    end else begin
      unique case (st_q)
        W_IDLE: begin
          if (go_i) begin
            st_d   = W_FETCH;
            tptr_d = base_i;
            fidx_d = '0;
            dir_d  = go_dir_i;
          end
        end
        W_FETCH: begin
          if (halt_i) st_d = W_HOLD;
          else if (mem_ack) begin
            if (mem_err) begin
              fault_o = 1'b1;
              st_d    = W_IDLE;
            end else begin
              unique case (fidx_q)
                2'd0: badr_d[HW_W-1:0]     = mem_rdata;
                2'd1: badr_d[PTR_W-1:HW_W] = mem_rdata;
                2'd2: rem_d = (mem_rdata[HW_W-1:1] == '0) ? (CNT_W'(1) << HW_W)
                                                          : {1'b0, mem_rdata[HW_W-1:1], 1'b0};
                default: eot_d = mem_rdata[LAST_FLAG];
              endcase
              fidx_d = fidx_q + 2'd1;
              if (fidx_q == 2'd3) begin
                tptr_d = tptr_q + PTR_W'(DESC_BYTES);
                st_d   = move_st;
              end
            end
          end
        end
        W_MRD: begin
          if (halt_i) st_d = W_HOLD;
          else if (mem_ack) begin
            if (mem_err) begin
              fault_o = 1'b1;
              st_d    = W_IDLE;
            end else begin
              dbuf_d = mem_rdata;
              st_d   = W_DOUT;
            end
          end
        end
        W_DOUT: begin
          if (halt_i) st_d = W_HOLD;
          else if (dev_out_ready) step = 1'b1;
        end
        W_DIN: begin
          if (halt_i) st_d = W_HOLD;
          else if (dev_in_valid) begin
            dbuf_d = dev_in_data;
            st_d   = W_MWR;
          end
        end
        W_MWR: begin
          if (halt_i) st_d = W_HOLD;
          else if (mem_ack) begin
            if (mem_err) begin
              fault_o = 1'b1;
              st_d    = W_IDLE;
            end else begin
              step = 1'b1;
            end
          end
        end
        default: st_d = W_HOLD;
      endcase

      if (step) begin
        badr_d = badr_q + PTR_W'(HW_BYTES);
        rem_d  = rem_q - CNT_W'(HW_BYTES);
        if (rem_q == CNT_W'(HW_BYTES)) begin
          if (eot_q) begin
            end_o = 1'b1;
            st_d  = W_IDLE;
          end else begin
            st_d   = W_FETCH;
            fidx_d = '0;
          end
        end else begin
          st_d = move_st;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= W_IDLE;
      tptr_q <= '0;
      fidx_q <= '0;
      badr_q <= '0;
      rem_q  <= '0;
      eot_q  <= 1'b0;
      dbuf_q <= '0;
      dir_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      tptr_q <= tptr_d;
      fidx_q <= fidx_d;
      badr_q <= badr_d;
      rem_q  <= rem_d;
      eot_q  <= eot_d;
      dbuf_q <= dbuf_d;
      dir_q  <= dir_d;
    end
  end

  always_comb begin
    mem_req  = (st_q == W_FETCH) || (st_q == W_MRD) || (st_q == W_MWR);
    mem_we   = (st_q == W_MWR);
    mem_addr = (st_q == W_FETCH) ? (tptr_q + {{(PTR_W-3){1'b0}}, fidx_q, 1'b0}) : badr_q;
  end

  assign mem_wdata     = dbuf_q;
  assign dev_out_valid = (st_q == W_DOUT);
  assign dev_out_data  = dbuf_q;
  assign dev_in_ready  = (st_q == W_DIN);

  // R14: an open request keeps its address until acknowledged
  a_r14_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !abort_i && !halt_i) |=> (mem_req && $stable(mem_addr)));

  // R13: direction cannot change during a transfer
  a_r13_dir_locked: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q != W_IDLE) && !go_i) |=> $stable(dir_q));

  // R4: data movement never runs with an empty count
  a_r4_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == W_MRD) || (st_q == W_DOUT) || (st_q == W_DIN) || (st_q == W_MWR)) |-> (rem_q != '0));

  // R11: after a stop nothing is requested
  a_r11_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!mem_req && !dev_in_ready && !dev_out_valid));

endmodule

// File: rtl/prd_dma_engine.sv
module prd_dma_engine
  import dma_pkg::*;
#(
  parameter int REG_AW      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic              dev_in_valid,
  input  logic [15:0]       dev_in_data,
  output logic              dev_in_ready,
  output logic              dev_out_valid,
  output logic [15:0]       dev_out_data,
  input  logic              dev_out_ready,
  input  logic              dev_irq,
  output logic              irq
);

  logic [SYNC_STAGES-1:0] rsync_q;
  logic                   rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_s_n = rsync_q[SYNC_STAGES-1];

  logic             go, go_dir, abort, halt, tbl_end, fault;
  logic [PTR_W-1:0] base;

  dma_regfile #(.REG_AW(REG_AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .dev_irq   (dev_irq),
    .end_i     (tbl_end),
    .fault_i   (fault),
    .go_o      (go),
    .go_dir_o  (go_dir),
    .abort_o   (abort),
    .halt_o    (halt),
    .base_o    (base),
    .irq_o     (irq)
  );

  dma_walker u_walk (
    .clk           (clk),
    .rst_n         (rst_s_n),
    .go_i          (go),
    .go_dir_i      (go_dir),
    .abort_i       (abort),
    .halt_i        (halt),
    .base_i        (base),
    .end_o         (tbl_end),
    .fault_o       (fault),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_rdata     (mem_rdata),
    .mem_ack       (mem_ack),
    .mem_err       (mem_err),
    .dev_in_valid  (dev_in_valid),
    .dev_in_data   (dev_in_data),
    .dev_in_ready  (dev_in_ready),
    .dev_out_valid (dev_out_valid),
    .dev_out_data  (dev_out_data),
    .dev_out_ready (dev_out_ready)
  );

endmodule

// File: tb/sim_prd_dma_engine.sv
module sim_prd_dma_engine;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] NO_ERR = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic        dev_in_valid;
  logic [15:0] dev_in_data;
  logic        dev_in_ready;
  logic        dev_out_valid;
  logic [15:0] dev_out_data;
  logic        dev_out_ready = 1'b1;
  logic        dev_irq = 1'b0;
  logic        irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  prd_dma_engine u0 (.*);

  // memory model: halfword array, one-cycle registered acknowledge
  logic [15:0] mem_arr [0:255];
  logic [31:0] err_addr = NO_ERR;
  int          acc_cnt = 0, mwr_cnt = 0;

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    mem_err <= 1'b0;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      acc_cnt <= acc_cnt + 1;
      if (mem_addr == err_addr) mem_err <= 1'b1;
      else if (mem_we) begin
        mem_arr[mem_addr[8:1]] <= mem_wdata;
        mwr_cnt <= mwr_cnt + 1;
      end else mem_rdata <= mem_arr[mem_addr[8:1]];
    end
  end

  // device source and sink
  int          src_taken = 0, src_mark = 0, src_len = 0;
  logic [15:0] src_pat = '0;
  int          snk_cnt = 0;
  logic [15:0] snk_arr [0:31];

  assign dev_in_valid = (src_taken - src_mark) < src_len;
  assign dev_in_data  = src_pat + 16'(src_taken - src_mark);

  always @(posedge clk) begin
    if (dev_in_valid && dev_in_ready) src_taken <= src_taken + 1;
    if (dev_out_valid && dev_out_ready) begin
      snk_arr[snk_cnt[4:0]] <= dev_out_data;
      snk_cnt <= snk_cnt + 1;
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic put_desc(input int slot, input logic [31:0] ba, input logic [15:0] cnt, input logic last);
    @(negedge clk);
    mem_arr[128 + slot*4]     <= ba[15:0];
    mem_arr[128 + slot*4 + 1] <= ba[31:16];
    mem_arr[128 + slot*4 + 2] <= cnt;
    mem_arr[128 + slot*4 + 3] <= {last, 15'b0};
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rreg(3'd2, s);
      if (!s[0]) return;
    end
    chk({tag, " timeout waiting for active to drop"}, 32'd1, 32'd0);
  endtask

  task automatic pulse_irq();
    @(negedge clk); dev_irq = 1'b1;
    @(negedge clk); dev_irq = 1'b0;
  endtask

  task automatic src_load(input int n, input logic [15:0] pat);
    @(negedge clk);
    src_mark = src_taken; src_len = n; src_pat = pat;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rreg(3'd0, v); chk("R1 cmd after reset", v, 0);
    rreg(3'd2, v); chk("R1 status after reset", v, 0);
    rreg(3'd4, v); chk("R1 pointer after reset", v, 0);
    chk("R1 irq after reset", {31'b0, irq}, 0);
    chk("R1 no request after reset", {31'b0, mem_req}, 0);
    wreg(3'd4, 32'h0000_0100);
    rreg(3'd4, v); chk("R1 pointer readback", v, 32'h100);
  endtask

  task automatic t_matched_to_mem();
    logic [31:0] v;
    int acc0;
    put_desc(0, 32'h0, 16'd8, 1'b1);
    src_load(4, 16'hA500);
    acc0 = acc_cnt;
    wreg(3'd0, 32'h09);
    rreg(3'd2, v); chk("R2 active after start", v, 32'h01);
    wait_idle("R6");
    for (int i = 0; i < 4; i++) chk("R3 device word in memory", {16'b0, mem_arr[i]}, {16'b0, 16'hA500 + 16'(i)});
    chk("R14 one service per access", acc_cnt - acc0, 8);
    rreg(3'd2, v); chk("R6 status before device end", v, 0);
    pulse_irq();
    rreg(3'd2, v); chk("R6 status after matched end", v, 32'h04);
    chk("R10 irq follows interrupt bit", {31'b0, irq}, 1);
    wreg(3'd2, 32'h04);
    rreg(3'd2, v); chk("R10 interrupt cleared by write one", v, 0);
    chk("R10 irq low after clear", {31'b0, irq}, 0);
    wreg(3'd0, 0);
  endtask

  task automatic t_multi_from_mem();
    logic [31:0] v;
    int s0, w0;
    for (int i = 0; i < 2; i++) mem_arr[32 + i] = 16'h1100 + 16'(i);
    for (int i = 0; i < 3; i++) mem_arr[64 + i] = 16'h2200 + 16'(i);
    put_desc(0, 32'h40, 16'd4, 1'b0);
    put_desc(1, 32'h80, 16'd7, 1'b1);
    s0 = snk_cnt; w0 = mwr_cnt;
    wreg(3'd0, 32'h01);
    wreg(3'd0, 32'h09);
    wait_idle("R4");
    chk("R4 words delivered over two entries, odd count", snk_cnt - s0, 5);
    for (int i = 0; i < 2; i++) chk("R4 first buffer order", {16'b0, snk_arr[s0 + i]}, {16'b0, 16'h1100 + 16'(i)});
    for (int i = 0; i < 3; i++) chk("R4 second buffer order", {16'b0, snk_arr[s0 + 2 + i]}, {16'b0, 16'h2200 + 16'(i)});
    chk("R13 late direction write ignored", mwr_cnt - w0, 0);
    rreg(3'd0, v); chk("R1 command readback", v, 32'h09);
    wreg(3'd0, 0);
  endtask

  task automatic t_table_short();
    logic [31:0] v;
    int w0;
    put_desc(0, 32'h0, 16'd4, 1'b1);
    w0 = mwr_cnt;
    src_load(6, 16'h3300);
    wreg(3'd0, 32'h09);
    wait_idle("R8");
    repeat (10) @(negedge clk);
    rreg(3'd2, v); chk("R8 status when table runs out", v, 0);
    chk("R8 no irq", {31'b0, irq}, 0);
    chk("R8 words written", mwr_cnt - w0, 2);
    chk("R8 device left holding data", src_taken - src_mark, 2);
    wreg(3'd0, 0);
    src_load(0, 16'h0);
  endtask

  task automatic t_device_early();
    logic [31:0] v;
    int w0;
    put_desc(0, 32'h0, 16'd0, 1'b1);
    w0 = mwr_cnt;
    src_load(10, 16'h4400);
    wreg(3'd0, 32'h09);
    for (int i = 0; i < 500 && (mwr_cnt - w0) < 10; i++) @(negedge clk);
    repeat (5) @(negedge clk);
    rreg(3'd2, v); chk("R5 zero count still active after 20 bytes", v, 32'h01);
    pulse_irq();
    rreg(3'd2, v); chk("R7 status after early device end", v, 32'h05);
    src_load(3, 16'h4500);
    repeat (15) @(negedge clk);
    chk("R7 no movement after halt", mwr_cnt - w0, 10);
    chk("R7 device not served after halt", src_taken - src_mark, 0);
    wreg(3'd4, 32'h1F0);
    rreg(3'd4, v); chk("R12 pointer write ignored while active", v, 32'h100);
    wreg(3'd2, 32'h04);
    rreg(3'd2, v); chk("R10 clear keeps active", v, 32'h01);
    chk("R10 irq low", {31'b0, irq}, 0);
    wreg(3'd0, 0);
    rreg(3'd2, v); chk("R11 stop clears active", v, 0);
    wreg(3'd4, 32'h1F0);
    rreg(3'd4, v); chk("R12 pointer write taken while idle", v, 32'h1F0);
    wreg(3'd4, 32'h100);
    src_load(0, 16'h0);
  endtask

  task automatic t_stop();
    logic [31:0] v;
    put_desc(0, 32'h0, 16'd16, 1'b1);
    src_load(0, 16'h0);
    wreg(3'd0, 32'h09);
    repeat (20) @(negedge clk);
    rreg(3'd2, v); chk("R11 waiting transfer active", v, 32'h01);
    wreg(3'd0, 32'h08);
    rreg(3'd2, v); chk("R11 status after stop", v, 0);
    src_load(2, 16'h5500);
    repeat (20) @(negedge clk);
    chk("R11 device ignored after stop", src_taken - src_mark, 0);
    chk("R11 no request after stop", {31'b0, mem_req}, 0);
    src_load(0, 16'h0);
    wreg(3'd0, 0);
  endtask

  task automatic t_mem_error();
    logic [31:0] v;
    int s0;
    mem_arr[32] = 16'h6600;
    put_desc(0, 32'h40, 16'd8, 1'b1);
    err_addr = 32'h42;
    s0 = snk_cnt;
    wreg(3'd0, 32'h01);
    wait_idle("R9");
    rreg(3'd2, v); chk("R9 status after memory error", v, 32'h02);
    chk("R9 irq stays low", {31'b0, irq}, 0);
    chk("R9 words before abort", snk_cnt - s0, 1);
    wreg(3'd2, 32'h02);
    rreg(3'd2, v); chk("R9 error cleared by write one", v, 0);
    err_addr = NO_ERR;
    wreg(3'd0, 0);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_matched_to_mem();
    t_multi_from_mem();
    t_table_short();
    t_device_early();
    t_stop();
    t_mem_error();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule